// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned binary words and reports one of three relations: A greater than B, A less than B, or A equal to B. Its basic unit is a 4-bit slice. A slice has three cascade inputs that carry the result of a less significant comparison. The slice looks at its bit pairs starting from the most significant one. The first pair that differs decides the slice result. Only when all four pairs match does the slice pass on a result derived from its cascade inputs.

The top level chains a parameterized number of slices in series to compare wider words. The three outputs of each slice drive the three cascade inputs of the next more significant slice directly, with no logic in between. The least significant slice sees fixed cascade levels (greater low, less low, equal high), so identical wide words report equal. The block is purely combinational, with no clock and no reset.

Because the inputs are treated as monotonic unsigned codes, packed BCD words also compare correctly as decimal numbers. The slice gives defined results for cascade patterns that are not one-hot. Outputs from several slices can therefore be merged in parallel trees.

Top module: `magCmpChain`

## Requirements
- R1: Within a slice, the most significant bit pair that differs decides the result. Greater is asserted when that A bit is 1 and the B bit is 0. Less is asserted in the opposite case. The cascade inputs then have no effect.
- R2: When a bit pair decides the result, exactly one of greater and less is high, and equal is low.
- R3: With all four pairs equal and the cascade equal input high, the slice outputs greater=0, less=0, equal=1, whatever the other two cascade inputs are.
- R4: With all pairs equal, equal-in low and only greater-in high, the outputs are 1,0,0 (greater, less, equal). With only less-in high, they are 0,1,0.
- R5: With all pairs equal, greater-in and less-in both high and equal-in low, all three outputs are 0.
- R6: With all pairs equal and all three cascade inputs low, the outputs are greater=1, less=1, equal=0.
- R7: In the chain, the lowest slice receives cascade levels greater=0, less=0, equal=1. Identical wide words therefore give aGtB=0, aLtB=0, aEqB=1.
- R8: The chain outputs match an unsigned comparison of the full words, which are 4*SLICES bits wide. Each slice's outputs feed the next higher slice's cascade inputs directly.
- R9: Packed BCD words, one decimal digit per slice, compare in the same order as their decimal values.
- R10: For every input pair, exactly one of the chain outputs aGtB, aLtB and aEqB is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aWide | input | 4*SLICES | Word A, unsigned, MSB first |
| bWide | input | 4*SLICES | Word B, unsigned, MSB first |
| aGtB | output | 1 | A is greater than B |
| aLtB | output | 1 | A is less than B |
| aEqB | output | 1 | A equals B |

## Verification
On every evaluation, the embedded assertions check four things:
- a pair-decided slice result is one-hot with equal low;
- an asserted equal-in wins whenever the words match;
- the chain result is one-hot;
- the chain result agrees with an unsigned compare of the wide words.

The full cascade truth table cannot be reached through the chain, because the chain fixes its lowest cascade levels. The odd patterns (both greater-in and less-in high, or all three low) therefore come only from the bench driving a lone slice. The bench also provides the BCD ordering scenario and the exhaustive sweep of the two-slice chain.

// File: rtl/magCmpPkg.sv
package magCmpPkg;
  localparam int SLICE_W = 4;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmpFlagsT;

  typedef struct packed {
    logic decided;
    logic aAhead;
  } cmpStrobeT;
endpackage

// File: rtl/magCmpCtrl.sv
module magCmpCtrl
  import magCmpPkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] pairGt,
  input  logic [W-1:0] pairLt,
  output cmpStrobeT    strobe
);
  // Scan upward so that the most significant differing pair overrides (R1)
  always_comb begin
    strobe = '0;
    for (int i = 0; i < W; i++) begin
      if (pairGt[i] || pairLt[i]) begin
        strobe.decided = 1'b1;
        strobe.aAhead  = pairGt[i];
      end
    end
  end

  always_comb begin
    if (strobe.decided)
      a_r1_decide_has_pair: assert ((pairGt | pairLt) != '0)
        else $error("R1 decided without a differing pair");
    else
      a_r1_undecided_all_equal: assert ((pairGt | pairLt) == '0)
        else $error("R1 undecided with a differing pair");
  end
endmodule

// File: rtl/magCmpData.sv
module magCmpData
  import magCmpPkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] aWord,
  input  logic [W-1:0] bWord,
  input  cmpFlagsT     casIn,
  input  cmpStrobeT    strobe,
  output logic [W-1:0] pairGt,
  output logic [W-1:0] pairLt,
  output cmpFlagsT     result
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : gPair
      assign pairGt[g] = aWord[g] & ~bWord[g];
      assign pairLt[g] = ~aWord[g] & bWord[g];
    end
  endgenerate

  always_comb begin
    if (strobe.decided) begin
      result.gt = strobe.aAhead;
      result.lt = ~strobe.aAhead;
      result.eq = 1'b0;
    end else begin
      result.eq = casIn.eq;
      result.gt = ~casIn.eq & ~casIn.lt;
      result.lt = ~casIn.eq & ~casIn.gt;
    end
  end

  always_comb begin
    if (strobe.decided)
      a_r2_decided_onehot: assert (!result.eq && $onehot({result.gt, result.lt}))
        else $error("R2 decided result not one-hot");
    if (aWord == bWord && casIn.eq)
      a_r3_equal_in_wins: assert (result == cmpFlagsT'(3'b001))
        else $error("R3 equal-in did not win");
  end
endmodule

// File: rtl/magCmpSlice.sv
module magCmpSlice
  import magCmpPkg::*;
(
  input  logic [SLICE_W-1:0] aNib,
  input  logic [SLICE_W-1:0] bNib,
  input  logic               casGt,
  input  logic               casLt,
  input  logic               casEq,
  output logic               outGt,
  output logic               outLt,
  output logic               outEq
);
  logic [SLICE_W-1:0] pairGt;
  logic [SLICE_W-1:0] pairLt;
  cmpStrobeT strobe;
  cmpFlagsT  casIn;
  cmpFlagsT  result;

  assign casIn = '{gt: casGt, lt: casLt, eq: casEq};

  magCmpData #(.W(SLICE_W)) uData (
    .aWord (aNib),
    .bWord (bNib),
    .casIn (casIn),
    .strobe(strobe),
    .pairGt(pairGt),
    .pairLt(pairLt),
    .result(result)
  );

  magCmpCtrl #(.W(SLICE_W)) uCtrl (
    .pairGt(pairGt),
    .pairLt(pairLt),
    .strobe(strobe)
  );

  assign outGt = result.gt;
  assign outLt = result.lt;
  assign outEq = result.eq;
endmodule

// File: rtl/magCmpChain.sv
module magCmpChain
  import magCmpPkg::*;
#(
  parameter int SLICES = 2
) (
  input  logic [SLICE_W*SLICES-1:0] aWide,
  input  logic [SLICE_W*SLICES-1:0] bWide,
  output logic                      aGtB,
  output logic                      aLtB,
  output logic                      aEqB
);
  localparam int TOTAL_W = SLICE_W * SLICES;

  cmpFlagsT link [SLICES+1];

  // Fixed levels into the least significant slice (R7)
  assign link[0] = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

  genvar s;
  generate
    for (s = 0; s < SLICES; s++) begin : gSlice
      magCmpSlice uSlice (
        .aNib (aWide[s*SLICE_W +: SLICE_W]),
        .bNib (bWide[s*SLICE_W +: SLICE_W]),
        .casGt(link[s].gt),
        .casLt(link[s].lt),
        .casEq(link[s].eq),
        .outGt(link[s+1].gt),
        .outLt(link[s+1].lt),
        .outEq(link[s+1].eq)
      );
    end
  endgenerate

  assign aGtB = link[SLICES].gt;
  assign aLtB = link[SLICES].lt;
  assign aEqB = link[SLICES].eq;

  logic [TOTAL_W-1:0] aChk;
  logic [TOTAL_W-1:0] bChk;
  assign aChk = aWide;
  assign bChk = bWide;

  always_comb begin
    a_r10_result_onehot: assert ($onehot({aGtB, aLtB, aEqB}))
      else $error("R10 chain result not one-hot");
    a_r8_unsigned_order: assert (aGtB == (aChk > bChk) && aLtB == (aChk < bChk))
      else $error("R8 chain order mismatch");
    if (aChk == bChk)
      a_r7_equal_words: assert (aEqB)
        else $error("R7 equal words not reported equal");
  end
endmodule

// File: tb/magCmpChain_test.sv
`timescale 1ns/1ps
module magCmpChain_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int vecCount = 0;
  int missCount = 0;

  logic [7:0] aWide = '0;
  logic [7:0] bWide = '0;
  logic aGtB, aLtB, aEqB;

  magCmpChain #(.SLICES(2)) uut (
    .aWide(aWide), .bWide(bWide),
    .aGtB(aGtB), .aLtB(aLtB), .aEqB(aEqB)
  );

  logic [3:0] sa = '0;
  logic [3:0] sb = '0;
  logic cGt = 1'b0, cLt = 1'b0, cEq = 1'b1;
  logic sGt, sLt, sEq;

  magCmpSlice sliceUut (
    .aNib(sa), .bNib(sb), .casGt(cGt), .casLt(cLt), .casEq(cEq),
    .outGt(sGt), .outLt(sLt), .outEq(sEq)
  );

  task automatic checkTrip(input string req, input logic [2:0] act, input logic [2:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s a=%0d b=%0d actual=%b expected=%b", req, aWide, bWide, act, exp);
    end
  endtask

  task automatic checkSlice(input string req, input logic [2:0] exp);
    vecCount++;
    if ({sGt, sLt, sEq} !== exp) begin
      missCount++;
      $display("FAIL %s a=%0d b=%0d cas=%b%b%b actual=%b expected=%b",
               req, sa, sb, cGt, cLt, cEq, {sGt, sLt, sEq}, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    missCount++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    logic [2:0] exp;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // initial state: both words zero, so equal (R7)
    checkTrip("R7", {aGtB, aLtB, aEqB}, 3'b001);

    // Lone slice: every word pair against every cascade pattern (R1..R6)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 8; c++) begin
          @(posedge clk);
          sa = a[3:0]; sb = b[3:0];
          {cGt, cLt, cEq} = c[2:0];
          @(negedge clk);
          if (a > b) checkSlice("R1", 3'b100);
          else if (a < b) checkSlice("R2", 3'b010);
          else if (cEq) checkSlice("R3", 3'b001);
          else if (cGt && !cLt) checkSlice("R4", 3'b100);
          else if (cLt && !cGt) checkSlice("R4", 3'b010);
          else if (cGt && cLt) checkSlice("R5", 3'b000);
          else checkSlice("R6", 3'b110);
        end
      end
    end

    // Two-slice chain, exhaustive (R8, R10, R7)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(posedge clk);
        aWide = a[7:0]; bWide = b[7:0];
        @(negedge clk);
        exp = {a > b, a < b, a == b};
        checkTrip((a == b) ? "R7" : "R8", {aGtB, aLtB, aEqB}, exp);
        if ($countones({aGtB, aLtB, aEqB}) != 1)
          checkTrip("R10", {aGtB, aLtB, aEqB}, exp);
      end
    end

    // Packed BCD, two digits (R9)
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        @(posedge clk);
        aWide = {4'(x / 10), 4'(x % 10)};
        bWide = {4'(y / 10), 4'(y % 10)};
        @(negedge clk);
        checkTrip("R9", {aGtB, aLtB, aEqB}, {x > y, x < y, x == y});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule